// File: doc/BRIEF.md
# Routed I2C Write Bridge

This block sits between one upstream I2C controller and eight downstream I2C buses. Every downstream bus carries an identical target device, and all the targets share one 7-bit address. The upstream controller therefore picks a target by naming a bus. It addresses the bridge as an ordinary write-only slave and sends three bytes in a fixed order: a bus-select byte, a target register byte and a data byte.

The bridge does not pass signals through. Once the data byte has been shifted in, it holds the upstream SCL low. While it holds the clock, it asks for the selected downstream bus on a request/grant pair. Other bridge instances may share that bus. When the bus is granted, the bridge's own master engine replays the write on it. The bridge then lets the upstream clock go. The acknowledge bit of the data byte tells the controller whether the downstream write succeeded.

Top module: `i2c_route_bridge`

## Requirements
- R1: A transfer whose first byte is the bridge address `SELF_ADDR` followed by a write bit (0) is acknowledged. Any other first byte, including the bridge address with the read bit (1), is not acknowledged, and every byte after it is ignored up to the next STOP.
- R2: The byte after the address is the bus select. A value from 0 to NBUS-1 is acknowledged. A value of NBUS or more is not acknowledged and starts no downstream activity.
- R3: The register byte is acknowledged. The acknowledge bit of the data byte is driven low only when the downstream write completed with every byte acknowledged.
- R4: From the falling SCL edge after the eighth data bit until the downstream write ends, the bridge holds the upstream SCL low.
- R5: Only the request line of the selected bus rises. Neither downstream line of that bus is driven before its grant is high. The request falls once the downstream sequence has finished.
- R6: The downstream write is START, then `{TGT_ADDR,0}`, then the register byte, then the data byte, then STOP. Bytes go MSB first and only the selected bus moves.
- R7: Downstream SDA changes only while downstream SCL is low, except at START and STOP.
- R8: When a downstream byte is not acknowledged, the bridge issues STOP, answers the upstream data byte with NACK, and sets `err_flag`. That flag clears only on reset.
- R9: If the bridge has released downstream SDA and reads it low while SCL is high, it releases both lines without a STOP, drops the request, answers the upstream data byte with NACK, and sets `err_flag`.
- R10: Each downstream SCL high and low half lasts 2*(`clk_div`+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| up_scl_i | input | 1 | Upstream SCL line level |
| up_sda_i | input | 1 | Upstream SDA line level |
| up_scl_oe | output | 1 | Pull upstream SCL low (clock stretch) |
| up_sda_oe | output | 1 | Pull upstream SDA low (acknowledge) |
| dn_sda_i | input | NBUS | Downstream SDA line levels |
| dn_scl_oe | output | NBUS | Pull downstream SCL low, one per bus |
| dn_sda_oe | output | NBUS | Pull downstream SDA low, one per bus |
| bus_req | output | NBUS | Ownership request, one per bus |
| bus_gnt | input | NBUS | Ownership grant, one per bus |
| clk_div | input | DIVW | Quarter-bit divider for the downstream clock |
| err_flag | output | 1 | Sticky downstream failure indicator |

## Verification
The assertions take three things for granted. First, a grant, once given, stays high for as long as its request is held. Second, `clk_div` is at least 2, so that the two-flop SDA synchronizer settles inside one quarter bit. Third, the upstream controller holds each SCL phase for many system clocks and changes SDA only while SCL is low. The stimulus stays inside these limits: the grant model follows the request one clock later unless a test holds the grant back, the divider is fixed at 3, and the upstream controller task uses 30-cycle half periods and waits out any stretch before it samples.

// File: rtl/i2c_route_pkg.sv
// Package: shared state encodings for the routed write bridge.
// Assumes: included first in compile order.
package i2c_route_pkg;

    // Upstream slave progress through one transfer.
    typedef enum logic [2:0] {
        UP_IDLE,
        UP_ADDR,
        UP_SEL,
        UP_REG,
        UP_DATA,
        UP_WAIT,
        UP_ACKSET,
        UP_SKIP
    } up_phase_t;

    // Downstream master sequence.
    typedef enum logic [2:0] {
        M_IDLE,
        M_REQ,
        M_START,
        M_BIT,
        M_STOP,
        M_DONE
    } mst_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: brings the upstream SCL/SDA into the clock domain and derives events.
// Assumes: lines idle high; each SCL phase spans several clocks.
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl,
    output logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [1:0] scl_pipe, sda_pipe;
    logic       scl_prev, sda_prev;

    // Two-flop synchronizers plus one stage of history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= 2'b11;
            sda_pipe <= 2'b11;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[0], scl_in};
            sda_pipe <= {sda_pipe[0], sda_in};
            scl_prev <= scl_pipe[1];
            sda_prev <= sda_pipe[1];
        end
    end

    // Edge and bus-condition decode from synchronized levels.
    always_comb begin
        scl      = scl_pipe[1];
        sda      = sda_pipe[1];
        scl_rise = scl && !scl_prev;
        scl_fall = !scl && scl_prev;
        start_ev = scl && scl_prev && sda_prev && !sda;
        stop_ev  = scl && scl_prev && !sda_prev && sda;
    end
endmodule

// File: rtl/i2c_up_slave.sv
// Module: write-only upstream slave. Decodes address, bus select, register
// and data bytes; stretches SCL after the data byte until the downstream
// write reports back, then acknowledges with its result.
// Assumes: synchronized inputs from i2c_line_sync.
module i2c_up_slave
    import i2c_route_pkg::*;
#(
    parameter int          NBUS      = 8,
    parameter logic [6:0]  SELF_ADDR = 7'h52,
    localparam int         SELW      = $clog2(NBUS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sda,
    input  logic            scl_rise,
    input  logic            scl_fall,
    input  logic            start_ev,
    input  logic            stop_ev,
    input  logic            wr_done,
    input  logic            wr_fail,
    output logic            scl_oe,
    output logic            sda_oe,
    output logic            wr_go,
    output logic [SELW-1:0] wr_sel,
    output logic [7:0]      wr_reg,
    output logic [7:0]      wr_data
);
    up_phase_t  phase;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic       ack_q;

    // Byte framing, acknowledge decisions and stretch control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= UP_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            ack_q   <= 1'b0;
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
            wr_go   <= 1'b0;
            wr_sel  <= '0;
            wr_reg  <= '0;
            wr_data <= '0;
        end else begin
            wr_go <= 1'b0;
            if (stop_ev) begin
                phase  <= UP_IDLE;
                sda_oe <= 1'b0;
                scl_oe <= 1'b0;
                bitcnt <= '0;
            end else if (start_ev) begin
                phase  <= UP_ADDR;
                sda_oe <= 1'b0;
                bitcnt <= '0;
            end else begin
                case (phase)
                    UP_IDLE, UP_SKIP: ;
                    UP_WAIT: if (wr_done) begin
                        sda_oe <= !wr_fail;
                        ack_q  <= 1'b0;
                        phase  <= UP_ACKSET;
                    end
                    UP_ACKSET: begin
                        scl_oe <= 1'b0;
                        phase  <= UP_DATA;
                    end
                    default: begin
                        if (scl_rise) begin
                            if (bitcnt < 4'd8) shreg <= {shreg[6:0], sda};
                            bitcnt <= bitcnt + 4'd1;
                        end
                        if (scl_fall && bitcnt == 4'd8) begin
                            case (phase)
                                UP_ADDR: begin
                                    ack_q  <= (shreg == {SELF_ADDR, 1'b0});
                                    sda_oe <= (shreg == {SELF_ADDR, 1'b0});
                                end
                                UP_SEL: begin
                                    ack_q  <= (int'(shreg) < NBUS);
                                    sda_oe <= (int'(shreg) < NBUS);
                                    wr_sel <= shreg[SELW-1:0];
                                end
                                UP_REG: begin
                                    ack_q  <= 1'b1;
                                    sda_oe <= 1'b1;
                                    wr_reg <= shreg;
                                end
                                default: begin
                                    wr_data <= shreg;
                                    wr_go   <= 1'b1;
                                    scl_oe  <= 1'b1;
                                    phase   <= UP_WAIT;
                                end
                            endcase
                        end
                        if (scl_fall && bitcnt == 4'd9) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            if (!ack_q)               phase <= UP_SKIP;
                            else if (phase == UP_ADDR) phase <= UP_SEL;
                            else if (phase == UP_SEL)  phase <= UP_REG;
                            else if (phase == UP_REG)  phase <= UP_DATA;
                            else                       phase <= UP_SKIP;
                        end
                    end
                endcase
            end
        end
    end

    // R4: while waiting on the downstream write the clock stays stretched.
    a_r4_hold_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase == UP_WAIT) && !$past(wr_done)) |-> scl_oe);

    // R2: a launch only ever follows an acknowledged select byte.
    a_r2_go_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> phase == UP_WAIT);
endmodule

// File: rtl/i2c_dn_master.sv
// Module: downstream write engine. Waits for a grant, then issues START,
// target address, register byte, data byte and STOP, with a quarter-bit
// timebase from a programmable divider; checks ACKs and watches for lost
// arbitration on its released bits.
// Assumes: div >= 2; targets do not stretch SCL; grant stays while requested.
module i2c_dn_master
    import i2c_route_pkg::*;
#(
    parameter int          NBUS     = 8,
    parameter logic [6:0]  TGT_ADDR = 7'h21,
    parameter int          DIVW     = 8,
    localparam int         SELW     = $clog2(NBUS),
    localparam int         FW       = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [SELW-1:0] sel,
    input  logic [7:0]      reg_b,
    input  logic [7:0]      data_b,
    input  logic [DIVW-1:0] div,
    input  logic            sda_line,
    input  logic            gnt_sel,
    output logic [SELW-1:0] idx,
    output logic            req_on,
    output logic            scl_low,
    output logic            sda_low,
    output logic            done,
    output logic            fail
);
    mst_state_t      state;
    logic [DIVW-1:0] divcnt;
    logic [1:0]      q;
    logic [FW-1:0]   frame;
    logic [3:0]      bitn;
    logic [1:0]      byten;
    logic            nack_q;
    logic [1:0]      sda_pipe;
    logic            tick, lost_now;

    assign tick     = (divcnt == div);
    assign lost_now = tick && state == M_BIT && q == 2'd2 && bitn != 4'd8
                      && frame[FW-1] && !sda_pipe[1];

    // Synchronize the selected bus SDA for ACK and arbitration sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_pipe <= 2'b11;
        else        sda_pipe <= {sda_pipe[0], sda_line};
    end

    // Sequencer: quarter-bit timing, bit shifting, ACK and arbitration checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= M_IDLE;
            divcnt  <= '0;
            q       <= '0;
            frame   <= '0;
            bitn    <= '0;
            byten   <= '0;
            nack_q  <= 1'b0;
            idx     <= '0;
            req_on  <= 1'b0;
            scl_low <= 1'b0;
            sda_low <= 1'b0;
            done    <= 1'b0;
            fail    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state == M_IDLE || state == M_REQ || state == M_DONE || tick)
                divcnt <= '0;
            else
                divcnt <= divcnt + 1'b1;
            case (state)
                M_IDLE: if (go) begin
                    idx    <= sel;
                    frame  <= {TGT_ADDR, 1'b0, reg_b, data_b};
                    req_on <= 1'b1;
                    fail   <= 1'b0;
                    nack_q <= 1'b0;
                    state  <= M_REQ;
                end
                M_REQ: if (gnt_sel) begin
                    q     <= '0;
                    state <= M_START;
                end
                M_START: if (tick) begin
                    q <= q + 2'd1;
                    case (q)
                        2'd0:    sda_low <= 1'b1;
                        2'd1:    scl_low <= 1'b1;
                        default: begin
                            state <= M_BIT;
                            q     <= '0;
                            bitn  <= '0;
                            byten <= '0;
                        end
                    endcase
                end
                M_BIT: if (tick) begin
                    q <= q + 2'd1;
                    case (q)
                        2'd0: sda_low <= (bitn == 4'd8) ? 1'b0 : !frame[FW-1];
                        2'd1: scl_low <= 1'b0;
                        2'd2: begin
                            if (bitn == 4'd8) nack_q <= sda_pipe[1];
                            else if (lost_now) begin
                                sda_low <= 1'b0;
                                scl_low <= 1'b0;
                                fail    <= 1'b1;
                                state   <= M_DONE;
                            end
                        end
                        default: begin
                            scl_low <= 1'b1;
                            if (bitn == 4'd8) begin
                                if (nack_q || byten == 2'd2) begin
                                    fail  <= nack_q;
                                    state <= M_STOP;
                                end else begin
                                    byten <= byten + 2'd1;
                                    bitn  <= '0;
                                end
                            end else begin
                                frame <= frame << 1;
                                bitn  <= bitn + 4'd1;
                            end
                        end
                    endcase
                end
                M_STOP: if (tick) begin
                    q <= q + 2'd1;
                    case (q)
                        2'd0:    sda_low <= 1'b1;
                        2'd1:    scl_low <= 1'b0;
                        2'd2:    sda_low <= 1'b0;
                        default: state   <= M_DONE;
                    endcase
                end
                default: begin
                    req_on <= 1'b0;
                    done   <= 1'b1;
                    state  <= M_IDLE;
                end
            endcase
        end
    end

    // R7: SDA holds while SCL is released during a data or ACK bit.
    a_r7_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == M_BIT && $past(state == M_BIT) && !scl_low && !$past(scl_low))
        |-> sda_low == $past(sda_low));

    // R9: after losing arbitration both lines are released at once.
    a_r9_release_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
        lost_now |=> (!scl_low && !sda_low && fail));

    // R5: the bus is never driven without the grant.
    a_r5_drive_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_low || sda_low) |-> (req_on && gnt_sel));
endmodule

// File: rtl/i2c_route_bridge.sv
// Module: top of the routed write bridge. Joins the upstream slave to the
// downstream master and fans the master out to NBUS open-drain bus pairs
// with per-bus request/grant.
// Assumes: *_oe outputs pull the line low when high; lines have pull-ups.
module i2c_route_bridge #(
    parameter int          NBUS      = 8,
    parameter logic [6:0]  SELF_ADDR = 7'h52,
    parameter logic [6:0]  TGT_ADDR  = 7'h21,
    parameter int          DIVW      = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            up_scl_i,
    input  logic            up_sda_i,
    output logic            up_scl_oe,
    output logic            up_sda_oe,
    input  logic [NBUS-1:0] dn_sda_i,
    output logic [NBUS-1:0] dn_scl_oe,
    output logic [NBUS-1:0] dn_sda_oe,
    output logic [NBUS-1:0] bus_req,
    input  logic [NBUS-1:0] bus_gnt,
    input  logic [DIVW-1:0] clk_div,
    output logic            err_flag
);
    localparam int SELW = $clog2(NBUS);

    logic            s_scl, s_sda, s_rise, s_fall, s_start, s_stop;
    logic            go, m_done, m_fail, m_req, m_scl, m_sda;
    logic [SELW-1:0] w_sel, m_idx;
    logic [7:0]      w_reg, w_data;

    i2c_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(up_scl_i), .sda_in(up_sda_i),
        .scl(s_scl), .sda(s_sda), .scl_rise(s_rise), .scl_fall(s_fall),
        .start_ev(s_start), .stop_ev(s_stop)
    );

    i2c_up_slave #(.NBUS(NBUS), .SELF_ADDR(SELF_ADDR)) u_slave (
        .clk(clk), .rst_n(rst_n), .sda(s_sda), .scl_rise(s_rise),
        .scl_fall(s_fall), .start_ev(s_start), .stop_ev(s_stop),
        .wr_done(m_done), .wr_fail(m_fail), .scl_oe(up_scl_oe),
        .sda_oe(up_sda_oe), .wr_go(go), .wr_sel(w_sel), .wr_reg(w_reg),
        .wr_data(w_data)
    );

    i2c_dn_master #(.NBUS(NBUS), .TGT_ADDR(TGT_ADDR), .DIVW(DIVW)) u_master (
        .clk(clk), .rst_n(rst_n), .go(go), .sel(w_sel), .reg_b(w_reg),
        .data_b(w_data), .div(clk_div), .sda_line(dn_sda_i[m_idx]),
        .gnt_sel(bus_gnt[m_idx]), .idx(m_idx), .req_on(m_req),
        .scl_low(m_scl), .sda_low(m_sda), .done(m_done), .fail(m_fail)
    );

    // Per-bus fan-out of the single master engine.
    for (genvar g = 0; g < NBUS; g++) begin : g_bus
        assign dn_scl_oe[g] = m_scl && (m_idx == SELW'(g));
        assign dn_sda_oe[g] = m_sda && (m_idx == SELW'(g));
        assign bus_req[g]   = m_req && (m_idx == SELW'(g));
    end

    // Sticky failure flag, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) err_flag <= 1'b0;
        else if (m_done && m_fail) err_flag <= 1'b1;
    end

    // R5: at most one bus is requested at a time.
    a_r5_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_req));

    // R6: only a requested bus has either line driven.
    a_r6_drive_on_requested: assert property (@(posedge clk) disable iff (!rst_n)
        ((dn_scl_oe | dn_sda_oe) & ~bus_req) == '0);

    // R8: the error flag never clears outside reset.
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(err_flag) |-> err_flag);
endmodule

// File: tb/i2c_route_bridge_bench.sv
module i2c_route_bridge_bench;
    localparam int NB = 8;
    localparam int H  = 30;
    localparam int DV = 3;
    localparam logic [6:0] ME  = 7'h52;
    localparam logic [7:0] TAW = 8'h42;

    logic clk = 0, rst_n = 0;
    always #4 clk = ~clk;

    logic tb_scl_low = 0, tb_sda_low = 0;
    logic up_scl_oe, up_sda_oe, err_flag;
    logic [NB-1:0] dn_scl_oe, dn_sda_oe, bus_req;
    logic [NB-1:0] bus_gnt = '0, hold = '0, rival = '0, tnack = '0, tlow = '0;
    logic [7:0] clk_div = 8'(DV);
    wire up_scl = !(tb_scl_low || up_scl_oe);
    wire up_sda = !(tb_sda_low || up_sda_oe);
    wire [NB-1:0] dn_scl = ~dn_scl_oe;
    wire [NB-1:0] dn_sda = ~(dn_sda_oe | tlow | rival);

    int checks = 0, errors = 0;
    bit fin = 0;

    i2c_route_bridge u_i2c_route_bridge (
        .clk(clk), .rst_n(rst_n), .up_scl_i(up_scl), .up_sda_i(up_sda),
        .up_scl_oe(up_scl_oe), .up_sda_oe(up_sda_oe), .dn_sda_i(dn_sda),
        .dn_scl_oe(dn_scl_oe), .dn_sda_oe(dn_sda_oe), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .clk_div(clk_div), .err_flag(err_flag)
    );

    // Grant model: follow the request unless a test holds the grant back.
    always @(negedge clk) bus_gnt <= bus_req & ~hold;

    // Every-cycle reference: a driven bus must be requested and granted (R5).
    always @(negedge clk) if (rst_n && !fin) begin
        checks++;
        for (int i = 0; i < NB; i++)
            if ((dn_scl_oe[i] || dn_sda_oe[i]) && !(bus_req[i] && bus_gnt[i])) begin
                errors++;
                $display("FAIL R5 bus %0d driven req=%0b gnt=%0b expected both 1",
                         i, bus_req[i], bus_gnt[i]);
            end
        if ($countones(bus_req) > 1) begin
            errors++;
            $display("FAIL R5 req=%b expected at most one", bus_req);
        end
    end

    // Behavioural downstream targets, one per bus.
    logic [7:0] pscl = '1, psda = '1;
    logic [7:0] tsh [NB];
    logic [23:0] lastb [NB];
    int tbit [NB], tidx [NB], tcnt [NB], tstops [NB], rise_t [NB], hmin [NB], hmax [NB];
    bit tact [NB], rflag [NB];
    int cyc = 0;
    initial for (int i = 0; i < NB; i++) begin
        tsh[i] = 0; lastb[i] = 0; tbit[i] = 0; tidx[i] = 0; tcnt[i] = 0;
        tstops[i] = 0; rise_t[i] = 0; hmin[i] = 9999; hmax[i] = 0;
        tact[i] = 0; rflag[i] = 0;
    end
    always @(posedge clk) begin
        cyc++;
        for (int i = 0; i < NB; i++) begin
            if (dn_scl[i] && pscl[i] && psda[i] && !dn_sda[i]) begin
                tact[i] = 1; tbit[i] = 0; tidx[i] = 0; rflag[i] = 0;
            end else if (dn_scl[i] && pscl[i] && !psda[i] && dn_sda[i]) begin
                if (tact[i]) tstops[i]++;
                tact[i] = 0; tlow[i] <= 0;
            end else if (tact[i] && !pscl[i] && dn_scl[i]) begin
                if (tbit[i] < 8) tsh[i] = {tsh[i][6:0], dn_sda[i]};
                tbit[i]++; rise_t[i] = cyc; rflag[i] = 1;
            end else if (tact[i] && pscl[i] && !dn_scl[i]) begin
                if (rflag[i]) begin
                    if (cyc - rise_t[i] < hmin[i]) hmin[i] = cyc - rise_t[i];
                    if (cyc - rise_t[i] > hmax[i]) hmax[i] = cyc - rise_t[i];
                end
                if (tbit[i] == 8) begin
                    lastb[i] = {lastb[i][15:0], tsh[i]};
                    tcnt[i]++;
                    tlow[i] <= !(tnack[i] && tidx[i] == 1);
                end else if (tbit[i] == 9) begin
                    tlow[i] <= 0; tbit[i] = 0; tidx[i]++;
                end
            end
        end
        pscl = dn_scl; psda = dn_sda;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic wc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up();
        tb_scl_low = 0;
        while (!up_scl) @(negedge clk);
    endtask

    task automatic up_start();
        tb_sda_low = 0; tb_scl_low = 0; wc(H);
        tb_sda_low = 1; wc(H);
        tb_scl_low = 1; wc(H);
    endtask

    task automatic up_stop();
        tb_sda_low = 1; wc(H);
        scl_up(); wc(H);
        tb_sda_low = 0; wc(H);
    endtask

    task automatic up_byte(input logic [7:0] b, output logic k);
        for (int n = 7; n >= 0; n--) begin
            tb_sda_low = !b[n]; wc(H);
            scl_up(); wc(H);
            tb_scl_low = 1;
        end
        tb_sda_low = 0; wc(H);
        scl_up(); wc(H / 2);
        k = !up_sda; wc(H / 2);
        tb_scl_low = 1; wc(H);
    endtask

    task automatic up_write(input logic [6:0] a, input logic rw, input logic [7:0] s,
                            input logic [7:0] r, input logic [7:0] d, output logic [3:0] ak);
        logic k;
        ak = 0;
        up_start();
        up_byte({a, rw}, k); ak[3] = k;
        if (k) begin
            up_byte(s, k); ak[2] = k;
            if (k) begin
                up_byte(r, k); ak[1] = k;
                if (k) begin up_byte(d, k); ak[0] = k; end
            end
        end
        up_stop();
    endtask

    int c0, s0, tot0, tot;
    logic [3:0] ak;

    function automatic int total_bytes();
        int t = 0;
        for (int i = 0; i < NB; i++) t += tcnt[i];
        return t;
    endfunction

    initial begin
        wc(5); rst_n = 1; wc(5);
        // Reset state
        chk(up_scl_oe == 0 && up_sda_oe == 0, "R4 reset upstream release", {up_scl_oe, up_sda_oe}, 0);
        chk(dn_scl_oe == 0 && dn_sda_oe == 0 && bus_req == 0, "R5 reset downstream idle", bus_req, 0);
        chk(err_flag == 0, "R8 reset error flag", err_flag, 0);

        // Normal write to bus 2
        c0 = tcnt[2]; s0 = tstops[2]; tot0 = total_bytes();
        up_write(ME, 0, 8'd2, 8'h1C, 8'hA5, ak);
        chk(ak == 4'b1111, "R1 R3 acks bus2", ak, 4'hF);
        chk(lastb[2] == {TAW, 8'h1C, 8'hA5}, "R6 bus2 bytes", lastb[2], {TAW, 8'h1C, 8'hA5});
        chk(tcnt[2] - c0 == 3 && total_bytes() - tot0 == 3, "R6 only bus2 bytes", tcnt[2] - c0, 3);
        chk(tstops[2] - s0 == 1, "R6 bus2 stop", tstops[2] - s0, 1);
        chk(hmin[2] == 2 * (DV + 1) && hmax[2] == 2 * (DV + 1), "R10 scl high width", hmax[2], 2 * (DV + 1));
        chk(bus_req == 0, "R5 request released", bus_req, 0);
        chk(err_flag == 0, "R8 no error after good write", err_flag, 0);

        // Delayed grant on bus 7: stretching
        hold[7] = 1;
        c0 = tcnt[7];
        fork
            up_write(ME, 0, 8'd7, 8'h03, 8'h5E, ak);
            begin
                wait (bus_req[7]); wc(300);
                chk(up_scl_oe == 1 && up_scl == 0, "R4 stretch while ungranted", up_scl_oe, 1);
                chk(dn_scl_oe[7] == 0 && dn_sda_oe[7] == 0, "R5 no drive before grant", dn_scl_oe[7], 0);
                hold[7] = 0;
            end
        join
        chk(ak == 4'b1111 && lastb[7] == {TAW, 8'h03, 8'h5E}, "R4 R6 bus7 write", lastb[7], {TAW, 8'h03, 8'h5E});

        // Bad select
        tot0 = total_bytes();
        up_write(ME, 0, 8'd9, 8'h11, 8'h22, ak);
        chk(ak == 4'b1000, "R2 select 9 nacked", ak, 4'h8);
        chk(total_bytes() == tot0, "R2 no downstream traffic", total_bytes() - tot0, 0);

        // Wrong address and read bit
        up_write(7'h53, 0, 8'd1, 8'h11, 8'h22, ak);
        chk(ak == 4'b0000, "R1 foreign address nacked", ak, 0);
        up_write(ME, 1, 8'd1, 8'h11, 8'h22, ak);
        chk(ak == 4'b0000, "R1 read bit nacked", ak, 0);
        tot = total_bytes();
        chk(tot == tot0 && err_flag == 0, "R1 ignored transfers no traffic", tot - tot0, 0);

        // Target NACK on bus 4
        tnack[4] = 1; c0 = tcnt[4]; s0 = tstops[4];
        up_write(ME, 0, 8'd4, 8'h77, 8'h99, ak);
        chk(ak == 4'b1110, "R3 R8 data nacked on target nack", ak, 4'hE);
        chk(tstops[4] - s0 == 1 && tcnt[4] - c0 == 2, "R8 stop after nack", tcnt[4] - c0, 2);
        chk(err_flag == 1, "R8 error flag set", err_flag, 1);
        tnack[4] = 0;

        // Arbitration loss on bus 5
        rival[5] = 1; c0 = tcnt[5];
        up_write(ME, 0, 8'd5, 8'h40, 8'h41, ak);
        chk(ak == 4'b1110, "R9 data nacked on lost arbitration", ak, 4'hE);
        chk(bus_req == 0 && dn_scl_oe == 0 && dn_sda_oe == 0, "R9 lines and request released",
            {bus_req, dn_scl_oe}, 0);
        chk(tcnt[5] == c0, "R9 no bytes seen", tcnt[5] - c0, 0);
        rival[5] = 0; wc(20);

        // Good write after failures: flag stays set
        up_write(ME, 0, 8'd0, 8'hF0, 8'h0F, ak);
        chk(ak == 4'b1111 && lastb[0] == {TAW, 8'hF0, 8'h0F}, "R6 bus0 write", lastb[0], {TAW, 8'hF0, 8'h0F});
        chk(err_flag == 1, "R8 error flag sticky", err_flag, 1);

        fin = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wc(190000);
        if (!fin) begin
            fin = 1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule